// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address. It reads one page table entry from main memory for each request. The virtual address has two parts. The upper page number selects an entry in a flat table. The lower 12-bit offset passes through to the result unchanged.

Two programmable registers describe the table. One register holds the table's start address. The other holds the number of entries. Before the walker reads memory, it compares the page number with the entry count. After the entry returns, it checks the entry's valid flag and its permission flags against the kind of access. The result is either a physical address or a fault code.

Only one translation is in progress at a time. The requester sees `req_ready` low from the moment a request is accepted until the cycle after the response. The memory side has one outstanding read. The walker holds the read request until the memory answers it.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0. The base and length registers are both 0, so every request raises the bound fault until the length register is written.
- R2: A configuration write with `cfg_sel` 0 loads the base register and with `cfg_sel` 1 loads the length register. A request accepted in the same cycle as the write still uses the old value. Requests accepted on later cycles use the new value.
- R3: A request whose page number (`req_vaddr[31:12]`) is equal to or greater than the length register returns fault code 1. No memory read is issued, and `rsp_valid` rises in the cycle after the request is accepted.
- R4: For an in-range page, `mem_req` rises in the cycle after acceptance with `mem_addr` = base + page number × 4. Both signals hold steady until the cycle in which `mem_rvalid` is 1.
- R5: An entry whose bit 0 (valid) is clear returns fault code 2. This includes the entry for virtual page 0, so that null-pointer references fault.
- R6: `req_acc` selects the access kind: 0 is read and needs entry bit 1, 1 is write and needs entry bit 2, 2 is execute and needs entry bit 3. Code 3 always faults. A missing permission returns fault code 3.
- R7: A successful translation returns fault code 0 and `rsp_paddr` = {entry[31:12], vaddr[11:0]}. Every faulting response carries `rsp_paddr` = 0.
- R8: `rsp_valid` is a one-cycle pulse. On the fetch path it comes in the cycle after `mem_rvalid`. `req_ready` is low from the cycle after acceptance until the cycle after the response.
- R9: When several checks fail at once, the fault codes take priority in this order: bound (1), then invalid (2), then protection (3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Write target: 0 base, 1 length |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 bound, 2 invalid, 3 protection |
| mem_req | output | 1 | Entry read request, held until answered |
| mem_addr | output | 32 | Entry byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Page table entry |

## Verification
A configuration write and the acceptance of a request can occur in the same clock cycle. The bench provokes this by driving a length or base write on the same cycle as a request. In one case, the new length would turn an in-range page into an out-of-range one. In another, the new base would move the entry address. The bench's behavioural model takes the old register values for that request and the new values for the request after it. It then judges whether the walker fetched, which address it used, and which fault code it returned.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    parameter int VA_W        = 32;
    parameter int PA_W        = 32;
    parameter int PAGE_BITS   = 12;
    parameter int PTE_W       = 32;
    parameter int ENTRY_SHIFT = 2;
    localparam int VPN_W      = VA_W - PAGE_BITS;
    localparam int FRAME_W    = PA_W - PAGE_BITS;
    localparam int PTE_RSVD_W = PTE_W - FRAME_W - 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUND   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } walk_st_e;

    typedef struct packed {
        logic [FRAME_W-1:0]    frame;
        logic [PTE_RSVD_W-1:0] rsvd;
        logic                  x;
        logic                  w;
        logic                  r;
        logic                  v;
    } pte_t;

    function automatic logic perm_ok(pte_t e, acc_e a);
        case (a)
            ACC_READ:  return e.r;
            ACC_WRITE: return e.w;
            ACC_EXEC:  return e.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split
    import pt_walker_pkg::*;
(
    input  logic [VA_W-1:0]      vaddr,
    input  logic [PA_W-1:0]      tbl_base,
    input  logic [VA_W-1:0]      tbl_len,
    output logic [PAGE_BITS-1:0] offset,
    output logic                 in_range,
    output logic [PA_W-1:0]      entry_addr
);
    logic [VPN_W-1:0] vpn;

    assign vpn        = vaddr[VA_W-1:PAGE_BITS];
    assign offset     = vaddr[PAGE_BITS-1:0];
    assign in_range   = VA_W'(vpn) < tbl_len;
    assign entry_addr = tbl_base + (PA_W'(vpn) << ENTRY_SHIFT);

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  logic [PTE_W-1:0]     entry,
    input  acc_e                 acc,
    input  logic [PAGE_BITS-1:0] offset,
    output fault_e               fault,
    output logic [PA_W-1:0]      paddr
);
    pte_t e;

    assign e = pte_t'(entry);

    always_comb begin
        if (!e.v) begin
            fault = FLT_INVALID;
        end else if (!perm_ok(e, acc)) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
        paddr = (fault == FLT_NONE) ? {e.frame, offset} : '0;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata
);
    walk_st_e             st_q;
    logic [PA_W-1:0]      base_q;
    logic [VA_W-1:0]      len_q;
    acc_e                 acc_q;
    logic [PAGE_BITS-1:0] off_q;
    logic [PA_W-1:0]      addr_q;
    fault_e               fault_q;
    logic [PA_W-1:0]      paddr_q;

    logic [PAGE_BITS-1:0] sp_off;
    logic                 sp_in_range;
    logic [PA_W-1:0]      sp_entry_addr;
    fault_e               ck_fault;
    logic [PA_W-1:0]      ck_paddr;
    logic                 accept;

    pt_addr_split u_split (
        .vaddr      (req_vaddr),
        .tbl_base   (base_q),
        .tbl_len    (len_q),
        .offset     (sp_off),
        .in_range   (sp_in_range),
        .entry_addr (sp_entry_addr)
    );

    pt_entry_check u_check (
        .entry  (mem_rdata),
        .acc    (acc_q),
        .offset (off_q),
        .fault  (ck_fault),
        .paddr  (ck_paddr)
    );

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_req   = (st_q == ST_FETCH);
    assign mem_addr  = addr_q;
    assign rsp_valid = (st_q == ST_RESP);
    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            base_q  <= '0;
            len_q   <= '0;
            acc_q   <= ACC_READ;
            off_q   <= '0;
            addr_q  <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            if (cfg_we) begin
                if (cfg_sel) len_q  <= VA_W'(cfg_wdata);
                else         base_q <= PA_W'(cfg_wdata);
            end
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        acc_q <= acc_e'(req_acc);
                        off_q <= sp_off;
                        if (sp_in_range) begin
                            addr_q <= sp_entry_addr;
                            st_q   <= ST_FETCH;
                        end else begin
                            fault_q <= FLT_BOUND;
                            paddr_q <= '0;
                            st_q    <= ST_RESP;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid) begin
                        fault_q <= ck_fault;
                        paddr_q <= ck_paddr;
                        st_q    <= ST_RESP;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R3: out-of-range page answers next cycle with no read
    a_r3_bound_no_read: assert property (@(posedge clk) disable iff (rst)
        (accept && !sp_in_range) |=> (rsp_valid && !mem_req && rsp_fault == 2'd1));

    // R4: read request and address hold until answered
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R8: response follows the memory answer
    a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid) |=> rsp_valid);

    // R8: response is a single-cycle pulse
    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8: no new request while one is in flight
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_req) |-> !req_ready);

    // R7: faults never carry an address
    a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    // R5: an entry without its valid bit never translates
    a_r5_invalid_faults: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid && !mem_rdata[0]) |=> (rsp_fault == 2'd2));

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic        cfg_sel;
    logic [31:0] cfg_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_acc;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic [31:0] m_base;
    logic [31:0] m_len;

    always #2.5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model_fault(input logic [31:0] pte, input logic [1:0] acc);
        if (!pte[0]) return 2'd2;
        if (acc == 2'd3) return 2'd3;
        if (!pte[1 + acc]) return 2'd3;
        return 2'd0;
    endfunction

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_len = data; else m_base = data;
    endtask

    task automatic xlate(input string tag, input logic [31:0] va, input logic [1:0] acc,
                         input logic [31:0] pte, input int lat,
                         input bit with_cfg, input logic sel, input logic [31:0] cdata);
        logic [19:0] vpn;
        logic [1:0]  ef;
        logic [31:0] epa;
        logic [31:0] eaddr;
        bit          bound;
        vpn   = va[31:12];
        bound = {12'd0, vpn} >= m_len;
        eaddr = m_base + {10'd0, vpn, 2'b00};
        @(negedge clk);
        chk({tag, " R8 ready when idle"}, {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        if (with_cfg) begin
            cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = cdata;
        end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        if (with_cfg) begin
            if (sel) m_len = cdata; else m_base = cdata;
        end
        if (bound) begin
            chk({tag, " R3 rsp next cycle"}, {31'd0, rsp_valid}, 32'd1);
            chk({tag, " R3 no mem read"},    {31'd0, mem_req},   32'd0);
            chk({tag, " R3 bound code"},     {30'd0, rsp_fault}, 32'd1);
            chk({tag, " R7 fault pa zero"},  rsp_paddr,          32'd0);
        end else begin
            ef  = model_fault(pte, acc);
            epa = (ef == 2'd0) ? {pte[31:12], va[11:0]} : 32'd0;
            chk({tag, " R4 mem_req"},  {31'd0, mem_req}, 32'd1);
            chk({tag, " R4 mem_addr"}, mem_addr,         eaddr);
            chk({tag, " R8 busy"},     {31'd0, req_ready}, 32'd0);
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                chk({tag, " R4 hold req"},  {31'd0, mem_req},   32'd1);
                chk({tag, " R4 hold addr"}, mem_addr,           eaddr);
                chk({tag, " R8 no early rsp"}, {31'd0, rsp_valid}, 32'd0);
            end
            mem_rvalid = 1'b1; mem_rdata = pte;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
            chk({tag, " R8 rsp after read"}, {31'd0, rsp_valid}, 32'd1);
            chk({tag, " R5/R6/R9 fault"},    {30'd0, rsp_fault}, {30'd0, ef});
            chk({tag, " R7 paddr"},          rsp_paddr,          epa);
        end
        @(negedge clk);
        chk({tag, " R8 pulse ends"}, {31'd0, rsp_valid}, 32'd0);
        chk({tag, " R8 ready again"}, {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_vaddr = '0; req_acc = '0;
        mem_rvalid = 1'b0; mem_rdata = '0;
        m_base = '0; m_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready",  {31'd0, req_ready}, 32'd1);
        chk("R1 reset rsp",    {31'd0, rsp_valid}, 32'd0);
        chk("R1 reset memreq", {31'd0, mem_req},   32'd0);

        // R1: length 0 after reset, page 0 bounds out
        xlate("r1_len_zero", 32'h0000_0123, 2'd0, 32'h0, 1, 0, 0, 0);

        cfg_write(1'b0, 32'h0001_0000);   // R2 base
        cfg_write(1'b1, 32'd16);          // R2 length

        // R5: null page marked invalid
        xlate("r5_null", 32'h0000_0000, 2'd0, 32'hFFFF_F00E, 2, 0, 0, 0);
        // R7: read on read-only page
        xlate("r7_read_ok", 32'h0000_3ABC, 2'd0, 32'hABCDE_003, 3, 0, 0, 0);
        // R6: write on read-only page
        xlate("r6_write_ro", 32'h0000_5004, 2'd1, 32'h12345_003, 1, 0, 0, 0);
        // R6: write on read-write page succeeds
        xlate("r6_write_rw", 32'h0000_5FFF, 2'd1, 32'h12345_007, 1, 0, 0, 0);
        // R6: execute-only page: exec passes, read faults
        xlate("r6_exec_ok", 32'h0000_7010, 2'd2, 32'h0F00D_009, 2, 0, 0, 0);
        xlate("r6_read_xo", 32'h0000_7010, 2'd0, 32'h0F00D_009, 1, 0, 0, 0);
        // R6: reserved access code always faults
        xlate("r6_rsvd_acc", 32'h0000_2000, 2'd3, 32'hFFFFF_00F, 1, 0, 0, 0);
        // R3: boundary pages 15 and 16
        xlate("r3_last_in", 32'h0000_F800, 2'd0, 32'h00001_003, 1, 0, 0, 0);
        xlate("r3_at_len",  32'h0001_0000, 2'd0, 32'h00001_003, 1, 0, 0, 0);
        xlate("r3_far",     32'hFFFF_FFFF, 2'd2, 32'h00001_00F, 1, 0, 0, 0);
        // R9: invalid beats missing permissions
        xlate("r9_inv_over_prot", 32'h0000_4000, 2'd1, 32'h55555_000, 1, 0, 0, 0);

        // R2: length shrink in the accept cycle: old length still applies
        xlate("r2_same_len", 32'h0000_A000, 2'd0, 32'h22222_003, 2, 1, 1'b1, 32'd4);
        xlate("r2_after_len", 32'h0000_A000, 2'd0, 32'h22222_003, 1, 0, 0, 0);
        // R2: base moved in the accept cycle: old base used, new base after
        xlate("r2_same_base", 32'h0000_2100, 2'd0, 32'h33333_003, 1, 1, 1'b0, 32'h0008_0000);
        xlate("r2_after_base", 32'h0000_2100, 2'd0, 32'h33333_003, 1, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule